// File: doc/BRIEF.md
# Bus Breakpoint and Watchpoint Comparators

This block watches a processor's buses and raises debug events. It holds two comparator units. Each unit is set to one job at a time. It can be a breakpoint on the program address, counted only on cycles where an instruction really executes. It can be a watchpoint on the data address, qualified by read strobes, write strobes or both. A unit matches an inclusive address window. Setting both ends of the window to the same value gives a single-address match.

The two units can also work as a pair. In address-with-data mode, unit 0 gives the address window and the direction, and unit 1's window is applied to the data value on the bus. In chained mode, a hit on unit 0 arms a flag. A later hit on unit 1 while the flag is armed produces the event and disarms the flag. A separate clear strobe also resets the flag.

The block only observes the buses. It never stalls them, so there is no valid/ready handshake and no back-pressure. Every bus cycle is sampled. The event outputs are plain registered pulses.

Top module: `dbg_analysis_units`

## Requirements
- R1: While reset is asserted, and on the first edge after it, both event outputs are 0 and the chain flag is disarmed.
- R2: An address matches when lo <= address <= hi, with both ends included. lo equal to hi matches one address. lo greater than hi matches nothing.
- R3: In execute mode (unit mode code 1), a unit hits on the program address only in cycles where exec_vld_i is 1.
- R4: In watch modes, a unit compares the data address. Code 2 hits on rd_i, code 3 hits on wr_i, and code 4 hits on either strobe. The data value has no effect.
- R5: With pair mode code 1, evt_o[0] fires when all of these hold: unit 0 is in code 2 or code 3, unit 0 hits its address window, and ddata_i lies in unit 1's window. Unit 0 in any other code gives no event. In every pair mode other than 0, evt_o[1] stays 0.
- R6: With pair mode code 2, a unit 0 hit arms the flag. evt_o[0] fires when unit 1 hits while the flag is already armed. A unit 1 hit in the same cycle that arms the flag gives no event.
- R7: A chained event disarms the flag, unless unit 0 also hits in that cycle, which re-arms it. chain_clr_i disarms the flag and wins over a unit 0 hit in the same cycle. Outside pair mode 2, the flag is held disarmed.
- R8: Every event is a single-cycle pulse, driven one clock after the qualifying bus cycle. Each qualifying cycle gives its own pulse, even on back-to-back cycles.
- R9: Pair mode 0 maps unit k's hit to evt_o[k]. A unit in mode 0 (off) never hits. Pair mode 3 produces no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pair_mode_i | input | 2 | 0 independent, 1 address with data, 2 chained, 3 none |
| u0_mode_i | input | 3 | Unit 0 job: 0 off, 1 execute, 2 read, 3 write, 4 read or write |
| u0_lo_i | input | CMP_W | Unit 0 window low end |
| u0_hi_i | input | CMP_W | Unit 0 window high end |
| u1_mode_i | input | 3 | Unit 1 job, same coding as unit 0 |
| u1_lo_i | input | CMP_W | Unit 1 window low end (data low end in mode 1) |
| u1_hi_i | input | CMP_W | Unit 1 window high end (data high end in mode 1) |
| chain_clr_i | input | 1 | Disarms the chain flag |
| pc_i | input | ADDR_W | Program address |
| exec_vld_i | input | 1 | Instruction at pc_i executes this cycle |
| daddr_i | input | ADDR_W | Data address |
| ddata_i | input | DATA_W | Data value being transferred |
| rd_i | input | 1 | Data read strobe |
| wr_i | input | 1 | Data write strobe |
| evt_o | output | 2 | Debug event pulses |

## Verification
The chained mode is where two functions share a cycle. Arming by unit 0 can coincide with unit 1 firing, and the clear strobe can coincide with a unit 0 hit. The bench provokes the first case by pointing both units at the same program address. It provokes the second by pulsing chain_clr_i on a cycle that executes the first breakpoint. A behavioural model with its own flag then decides, every clock, whether the next cycle must show an event. In the address-with-data mode, the bench crosses address hits with data matches and opposite strobes, so that the address test and the data test are seen to agree in one cycle.

// File: rtl/dbg_au_pkg.sv
package dbg_au_pkg;
  typedef enum logic [2:0] {
    AU_OFF  = 3'd0,
    AU_EXEC = 3'd1,
    AU_RD   = 3'd2,
    AU_WR   = 3'd3,
    AU_RDWR = 3'd4
  } au_mode_e;

  typedef enum logic [1:0] {
    PR_INDEP     = 2'd0,
    PR_ADDR_DATA = 2'd1,
    PR_CHAIN     = 2'd2,
    PR_NONE      = 2'd3
  } pair_mode_e;
endpackage

// File: rtl/dbg_au_range_cmp.sv
module dbg_au_range_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         in_o
);
  // inclusive window; lo > hi yields an empty window
  assign in_o = (val_i >= lo_i) && (val_i <= hi_i);
endmodule

// File: rtl/dbg_au_unit.sv
module dbg_au_unit
  import dbg_au_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CMP_W  = 16
) (
  input  au_mode_e          mode_i,
  input  logic              data_sel_i,
  input  logic [CMP_W-1:0]  lo_i,
  input  logic [CMP_W-1:0]  hi_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              exec_vld_i,
  input  logic [ADDR_W-1:0] daddr_i,
  input  logic [DATA_W-1:0] ddata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              hit_o
);
  logic [CMP_W-1:0] addr_op;
  logic [CMP_W-1:0] data_op;
  logic             addr_in;
  logic             data_in;

  always_comb begin
    addr_op = '0;
    data_op = '0;
    if (mode_i == AU_EXEC) addr_op[ADDR_W-1:0] = pc_i;
    else                   addr_op[ADDR_W-1:0] = daddr_i;
    data_op[DATA_W-1:0] = ddata_i;
  end

  dbg_au_range_cmp #(.W(CMP_W)) u_addr_cmp (
    .val_i(addr_op), .lo_i(lo_i), .hi_i(hi_i), .in_o(addr_in)
  );

  dbg_au_range_cmp #(.W(CMP_W)) u_data_cmp (
    .val_i(data_op), .lo_i(lo_i), .hi_i(hi_i), .in_o(data_in)
  );

  always_comb begin
    if (data_sel_i) begin
      hit_o = data_in;
    end else begin
      unique case (mode_i)
        AU_EXEC: hit_o = addr_in && exec_vld_i;
        AU_RD:   hit_o = addr_in && rd_i;
        AU_WR:   hit_o = addr_in && wr_i;
        AU_RDWR: hit_o = addr_in && (rd_i || wr_i);
        default: hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dbg_au_chain.sv
module dbg_au_chain (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic clr_i,
  input  logic first_i,
  input  logic second_i,
  output logic fire_o
);
  logic armed_q;

  assign fire_o = enable_i && armed_q && second_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (!enable_i || clr_i) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= (armed_q && !fire_o) || first_i;
    end
  end

  // R7: a clear strobe always leaves the flag disarmed
  assert_clr_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !armed_q);

  // R6: a first-breakpoint hit in chained mode arms the flag
  assert_arm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && first_i && !clr_i) |=> armed_q);

  // R7: firing without a new first hit disarms
  assert_fire_disarms_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !first_i) |=> !armed_q);
endmodule

// File: rtl/dbg_analysis_units.sv
module dbg_analysis_units
  import dbg_au_pkg::*;
#(
  parameter  int ADDR_W = 16,
  parameter  int DATA_W = 16,
  localparam int CMP_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        pair_mode_i,
  input  logic [2:0]        u0_mode_i,
  input  logic [CMP_W-1:0]  u0_lo_i,
  input  logic [CMP_W-1:0]  u0_hi_i,
  input  logic [2:0]        u1_mode_i,
  input  logic [CMP_W-1:0]  u1_lo_i,
  input  logic [CMP_W-1:0]  u1_hi_i,
  input  logic              chain_clr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              exec_vld_i,
  input  logic [ADDR_W-1:0] daddr_i,
  input  logic [DATA_W-1:0] ddata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [1:0]        evt_o
);
  localparam int NUM_UNITS = 2;

  pair_mode_e             pair;
  au_mode_e               mode   [NUM_UNITS];
  logic [CMP_W-1:0]       lo     [NUM_UNITS];
  logic [CMP_W-1:0]       hi     [NUM_UNITS];
  logic [NUM_UNITS-1:0]   hit;
  logic                   chain_fire;
  logic                   dir_ok;
  logic [NUM_UNITS-1:0]   evt_d;
  logic [NUM_UNITS-1:0]   evt_q;

  assign pair    = pair_mode_e'(pair_mode_i);
  assign mode[0] = au_mode_e'(u0_mode_i);
  assign mode[1] = au_mode_e'(u1_mode_i);
  assign lo[0]   = u0_lo_i;
  assign lo[1]   = u1_lo_i;
  assign hi[0]   = u0_hi_i;
  assign hi[1]   = u1_hi_i;

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
    logic data_sel;
    // the last unit turns into the data comparator when ganged
    assign data_sel = (k == NUM_UNITS - 1) && (pair == PR_ADDR_DATA);

    dbg_au_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) u_unit (
      .mode_i    (mode[k]),
      .data_sel_i(data_sel),
      .lo_i      (lo[k]),
      .hi_i      (hi[k]),
      .pc_i      (pc_i),
      .exec_vld_i(exec_vld_i),
      .daddr_i   (daddr_i),
      .ddata_i   (ddata_i),
      .rd_i      (rd_i),
      .wr_i      (wr_i),
      .hit_o     (hit[k])
    );
  end

  dbg_au_chain u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(pair == PR_CHAIN),
    .clr_i   (chain_clr_i),
    .first_i (hit[0]),
    .second_i(hit[1]),
    .fire_o  (chain_fire)
  );

  assign dir_ok = (mode[0] == AU_RD) || (mode[0] == AU_WR);

  always_comb begin
    evt_d = '0;
    unique case (pair)
      PR_INDEP:     evt_d = hit;
      PR_ADDR_DATA: evt_d[0] = dir_ok && hit[0] && hit[1];
      PR_CHAIN:     evt_d[0] = chain_fire;
      default:      evt_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_d;
  end

  assign evt_o = evt_q;

  // R3: an independent execute breakpoint event traces back to an executed cycle
  assert_bp_exec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o[0] && $past(pair_mode_i) == 2'd0 && $past(u0_mode_i) == 3'd1)
      |-> $past(exec_vld_i));

  // R2: such an event came from a program address inside the window
  assert_in_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o[0] && $past(pair_mode_i) == 2'd0 && $past(u0_mode_i) == 3'd1)
      |-> ($past(pc_i) >= $past(u0_lo_i) && $past(pc_i) <= $past(u0_hi_i)));

  // R5: ganged modes keep the upper event quiet
  assert_upper_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_mode_i != 2'd0) |=> !evt_o[1]);

  // R5: an address-with-data event needs a bus transfer in the prior cycle
  assert_addr_data_xfer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o[0] && $past(pair_mode_i) == 2'd1) |-> $past(rd_i || wr_i));
endmodule

// File: tb/dbg_analysis_units_test.sv
module dbg_analysis_units_test;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    pair = '0;
  logic [2:0]    m0 = '0, m1 = '0;
  logic [15:0]   lo0 = '0, hi0 = '0, lo1 = '0, hi1 = '0;
  logic          clr = 1'b0;
  logic [AW-1:0] pc = '0;
  logic          ev = 1'b0;
  logic [AW-1:0] da = '0;
  logic [DW-1:0] dd = '0;
  logic          rd = 1'b0, wr = 1'b0;
  logic [1:0]    evt_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R1";
  logic [1:0] exp_evt = '0;
  bit m_armed = 1'b0;
  logic [15:0] lf = 16'hACE1;

  always #5 clk = ~clk;

  dbg_analysis_units #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pair_mode_i(pair),
    .u0_mode_i(m0), .u0_lo_i(lo0), .u0_hi_i(hi0),
    .u1_mode_i(m1), .u1_lo_i(lo1), .u1_hi_i(hi1),
    .chain_clr_i(clr), .pc_i(pc), .exec_vld_i(ev),
    .daddr_i(da), .ddata_i(dd), .rd_i(rd), .wr_i(wr), .evt_o(evt_o)
  );

  function automatic bit unit_hits(int mode, int l, int h, int p, bit e,
                                   int a, bit r, bit w);
    int addr = (mode == 1) ? p : a;
    bit inside_win = (addr >= l) && (addr <= h);
    if (mode == 1) return inside_win && e;
    if (mode == 2) return inside_win && r;
    if (mode == 3) return inside_win && w;
    if (mode == 4) return inside_win && (r || w);
    return 1'b0;
  endfunction

  // behavioural reference, evaluated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_evt <= 2'b00;
      m_armed = 1'b0;
    end else begin
      bit h0, h1, dmatch, fire;
      h0 = unit_hits(int'(m0), int'(lo0), int'(hi0), int'(pc), ev, int'(da), rd, wr);
      h1 = unit_hits(int'(m1), int'(lo1), int'(hi1), int'(pc), ev, int'(da), rd, wr);
      dmatch = (int'(dd) >= int'(lo1)) && (int'(dd) <= int'(hi1));
      fire = (pair == 2'd2) && m_armed && h1;
      case (pair)
        2'd0: exp_evt <= {h1, h0};
        2'd1: exp_evt <= {1'b0, ((m0 == 3'd2) || (m0 == 3'd3)) && h0 && dmatch};
        2'd2: exp_evt <= {1'b0, fire};
        default: exp_evt <= 2'b00;
      endcase
      if (pair != 2'd2 || clr) m_armed = 1'b0;
      else                     m_armed = (m_armed && !fire) || h0;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (evt_o !== exp_evt) begin
      fails++;
      $display("FAIL %s: evt_o=%b expected %b at cycle %0d", cur_req, evt_o, exp_evt, cycles);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 50000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exec_at(logic [15:0] a, bit e);
    pc = a; ev = e; tick(1);
  endtask

  initial begin
    // R1: outputs quiet during reset and right after release
    cur_req = "R1";
    pair = 2'd0; m0 = 3'd1; lo0 = 16'h0; hi0 = 16'hFFFF; ev = 1'b1;
    tick(3);
    ev = 1'b0;
    rst_n = 1'b1;
    tick(2);

    // R3: execute breakpoints, with cycles whose fetch is discarded
    cur_req = "R3";
    m0 = 3'd1; lo0 = 16'h0100; hi0 = 16'h010F;
    m1 = 3'd1; lo1 = 16'h0200; hi1 = 16'h0200;
    for (int i = 0; i < 40; i++) exec_at(16'h00F8 + 16'(i), (i % 3) != 0);
    exec_at(16'h0200, 1'b1); exec_at(16'h0200, 1'b0); exec_at(16'h0201, 1'b1);

    // R8: back-to-back qualifying cycles give one pulse each
    cur_req = "R8";
    for (int i = 0; i < 6; i++) exec_at(16'h0100, 1'b1);
    exec_at(16'h0100, 1'b0);

    // R2: window edges and an empty window
    cur_req = "R2";
    for (int i = 0; i < 4; i++) begin
      exec_at(16'h00FF, 1'b1); exec_at(16'h0100, 1'b1);
      exec_at(16'h010F, 1'b1); exec_at(16'h0110, 1'b1);
    end
    lo0 = 16'h0300; hi0 = 16'h02FF;
    for (int i = 0; i < 32; i++) exec_at(16'h02F0 + 16'(i), 1'b1);
    ev = 1'b0;

    // R4: read, write and both-direction watches; data value irrelevant
    cur_req = "R4";
    m0 = 3'd2; lo0 = 16'h0040; hi0 = 16'h004F;
    m1 = 3'd3; lo1 = 16'h0048; hi1 = 16'h0048;
    for (int i = 0; i < 80; i++) begin
      step();
      da = 16'h0038 + {11'd0, lf[4:0]}; dd = lf; rd = lf[6]; wr = lf[9];
      pc = 16'h0044; ev = lf[3];
      tick(1);
    end
    m1 = 3'd4;
    for (int i = 0; i < 60; i++) begin
      step();
      da = 16'h0046 + {13'd0, lf[2:0]}; dd = ~lf; rd = lf[5]; wr = lf[11];
      tick(1);
    end

    // R9: off units and the no-event pair code
    cur_req = "R9";
    m0 = 3'd0; m1 = 3'd0; lo0 = 16'h0; hi0 = 16'hFFFF; lo1 = 16'h0; hi1 = 16'hFFFF;
    for (int i = 0; i < 30; i++) begin
      step(); pc = lf; ev = 1'b1; da = lf; rd = 1'b1; wr = lf[0]; tick(1);
    end
    pair = 2'd3; m0 = 3'd4; m1 = 3'd1;
    for (int i = 0; i < 30; i++) begin
      step(); pc = lf; ev = 1'b1; da = ~lf; rd = lf[1]; wr = lf[2]; tick(1);
    end

    // R5: address with data, read then write direction, then illegal both
    cur_req = "R5";
    pair = 2'd1; m0 = 3'd2; lo0 = 16'h0080; hi0 = 16'h0083;
    m1 = 3'd1; lo1 = 16'h0055; hi1 = 16'h0055;
    for (int i = 0; i < 90; i++) begin
      step();
      da = 16'h007E + {13'd0, lf[2:0]};
      dd = lf[4] ? 16'h0055 : {8'd0, lf[15:8]};
      rd = lf[7]; wr = lf[10]; pc = 16'h0055; ev = 1'b1;
      tick(1);
    end
    m0 = 3'd3;
    for (int i = 0; i < 60; i++) begin
      step();
      da = 16'h007E + {13'd0, lf[2:0]};
      dd = lf[5] ? 16'h0055 : 16'h0054;
      rd = lf[8]; wr = lf[1];
      tick(1);
    end
    m0 = 3'd4;
    for (int i = 0; i < 30; i++) begin
      step(); da = 16'h0081; dd = 16'h0055; rd = lf[0]; wr = lf[1]; tick(1);
    end
    rd = 1'b0; wr = 1'b0; ev = 1'b0;

    // R6: chained breakpoints, directed order checks
    cur_req = "R6";
    pair = 2'd2; m0 = 3'd1; lo0 = 16'h0010; hi0 = 16'h0010;
    m1 = 3'd1; lo1 = 16'h0020; hi1 = 16'h0020;
    exec_at(16'h0020, 1'b1);
    exec_at(16'h0010, 1'b1);
    exec_at(16'h0030, 1'b1);
    exec_at(16'h0020, 1'b1);
    exec_at(16'h0020, 1'b1);
    exec_at(16'h0010, 1'b0);
    exec_at(16'h0020, 1'b1);
    // both units on one address: arming cycle does not fire
    lo1 = 16'h0010; hi1 = 16'h0010;
    exec_at(16'h0010, 1'b1);
    exec_at(16'h0010, 1'b1);
    exec_at(16'h0010, 1'b1);
    exec_at(16'h0030, 1'b1);

    // R7: clear against a same-cycle arm, and leaving chained mode
    cur_req = "R7";
    lo1 = 16'h0020; hi1 = 16'h0020;
    exec_at(16'h0020, 1'b1);
    exec_at(16'h0010, 1'b1);
    clr = 1'b1; exec_at(16'h0010, 1'b1); clr = 1'b0;
    exec_at(16'h0020, 1'b1);
    exec_at(16'h0010, 1'b1);
    pair = 2'd0; exec_at(16'h0030, 1'b1);
    pair = 2'd2; exec_at(16'h0020, 1'b1);
    for (int i = 0; i < 150; i++) begin
      step();
      case (lf[1:0])
        2'd0: pc = 16'h0010;
        2'd1: pc = 16'h0020;
        default: pc = 16'h0030;
      endcase
      ev = lf[5] | lf[6];
      clr = (lf[12:10] == 3'd0);
      tick(1);
    end
    clr = 1'b0; ev = 1'b0;
    tick(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule